// File: doc/BRIEF.md
# Stopwatch and Countdown Timer Controller

This block holds the time of a five-digit stopwatch that doubles as a countdown timer, together with the state machine that interprets four shared push buttons. It runs from a slow system clock (10 Hz by default) and derives a one-second count enable from it. The buttons arrive already synchronized, as single-cycle press pulses. The time is kept as five BCD digits: hours, tens of minutes, minutes, tens of seconds and seconds.

In stopwatch mode the time counts up. A lap view freezes the shown value while counting goes on underneath. In timer mode the user first picks the hour, tens-of-minute or minute digit and steps it, then starts a countdown. When the countdown reaches zero an alarm is raised, and the alarm can be snoozed for five minutes. The display bus carries either the live time or the lap snapshot. Segment decoding and debouncing belong to neighbouring blocks.

When several buttons pulse in the same cycle, the reset button wins, then SET, then MODE_INC, then START_STOP.

Top module: `sw_timer_ctrl`

## Requirements
- R1: While counting, the time changes by one second every TICKS_PER_SEC clock cycles. The first change comes exactly TICKS_PER_SEC rising edges after the edge that samples the START_STOP press, because the second divider restarts whenever counting resumes.
- R2: `disp_time` is packed as {H, UM, LM, US, LS} with 4-bit BCD digits and H in bits 19:16. LS, LM and H count modulo 10 and US and UM count modulo 6. Counting up carries into the next digit, counting down borrows from it, and every digit always holds a legal value.
- R3: Holding `rst_n` low or pulsing `btn_reset` gives time 0:00:00, stopwatch mode, no counting, no lap view, no alarm, no snooze and the selection at the hour digit.
- R4: Each START_STOP press toggles between counting and paused. While paused in stopwatch mode the time holds.
- R5: In stopwatch mode a SET press turns on the lap view. The display then holds the time captured at the press while the counter keeps running. A second SET press shows the live time again.
- R6: A MODE_INC press in stopwatch mode enters timer mode. It clears the time to 0:00:00, pauses counting, drops the lap view and selects the hour digit.
- R7: In timer mode, with no alarm and no snooze, each SET press moves `sel_digit` from 0 (hour) to 1 (tens of minutes) to 2 (minutes) and back to 0.
- R8: In timer mode, while paused with no alarm and no snooze, MODE_INC increments the selected digit and wraps within that digit's modulus without carrying. The press is ignored while counting.
- R9: In timer mode the time counts down. On the second that reaches 0:00:00, `alarm_on` rises and counting stops.
- R10: The countdown never goes below 0:00:00. At zero the one-second enables leave the time unchanged, even if START_STOP sets the counting flag.
- R11: A SET press while the alarm is on clears the alarm, raises `snoozing`, loads 0:05:00 and starts counting down. When the count reaches zero again the alarm rises again.
- R12: While the alarm or snooze is active, START_STOP and MODE_INC have no effect. Only the reset button returns the block to stopwatch mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (10 Hz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_reset | input | 1 | One-cycle press of the reset button |
| btn_startstop | input | 1 | One-cycle press of the start/stop button |
| btn_set | input | 1 | One-cycle press of the set / lap / snooze button |
| btn_modeinc | input | 1 | One-cycle press of the mode / increment button |
| disp_time | output | 20 | Displayed time {H,UM,LM,US,LS}, BCD |
| alarm_on | output | 1 | Countdown has reached zero |
| timer_mode | output | 1 | 1 in timer mode, 0 in stopwatch mode |
| counting | output | 1 | Counting enabled |
| lap_view | output | 1 | Display shows the lap snapshot |
| snoozing | output | 1 | Snooze countdown is active |
| sel_digit | output | 2 | Digit chosen for setting: 0 hour, 1 tens of minutes, 2 minutes |

## Verification
A button press is sampled on one rising edge, and every flag and the display reflect it right after that edge. Time steps fall exactly TICKS_PER_SEC edges after the edge that started counting, and then every TICKS_PER_SEC edges. The bench drives each press for exactly one cycle from a falling edge. It counts the falling edges it waits from that press and samples on a falling edge, so every expected value is checked one edge before and on the edge where it becomes due, for example the last nonzero second and the zero second of a countdown.

// File: rtl/sw_pkg.sv
// Shared constants and types for the stopwatch/timer controller.
// Assumes five BCD digits; digit 0 is the seconds units digit.
package sw_pkg;
    localparam int NDIG = 5;
    localparam int DW   = 4;
    localparam int TW   = NDIG * DW;

    typedef logic [TW-1:0] time_t;

    // Digit chosen for setting in timer mode; order is the SET cycling order.
    typedef enum logic [1:0] {
        SEL_HR = 2'd0,
        SEL_UM = 2'd1,
        SEL_LM = 2'd2
    } sel_e;

    localparam time_t SNOOZE_TIME = 20'h00500;

    // Modulus of digit idx: tens-of-seconds and tens-of-minutes count to 6.
    function automatic int digit_mod(input int idx);
        return (idx == 1 || idx == 3) ? 6 : 10;
    endfunction
endpackage

// File: rtl/sw_bcd_digit.sv
// One BCD digit with a parameterized modulus.
// Priority: clear, load, step up (or bump), step down. Assumes up and dn are exclusive.
module sw_bcd_digit #(
    parameter int MOD = 10,
    parameter int W   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         up,
    input  logic         dn,
    input  logic         bump,
    output logic [W-1:0] val,
    output logic         at_max,
    output logic         at_zero
);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    logic [W-1:0] q;

    // Digit register: clear, load, wrap-around step up or down.
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (clr)       q <= '0;
        else if (ld)        q <= ld_val;
        else if (up | bump) q <= (q == TOP) ? '0 : q + 1'b1;
        else if (dn)        q <= (q == '0) ? TOP : q - 1'b1;
    end

    assign val     = q;
    assign at_max  = (q == TOP);
    assign at_zero = (q == '0);
endmodule

// File: rtl/sw_time_cnt.sv
// Five-digit time counter {H,UM,LM,US,LS} with carry/borrow chaining.
// A digit steps when all lower digits sit at their wrap point; bump edits one digit alone.
module sw_time_cnt
    import sw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       ld,
    input  time_t      ld_val,
    input  logic       up,
    input  logic       dn,
    input  logic       bump,
    input  logic [2:0] bump_idx,
    output time_t      now,
    output logic       is_zero,
    output logic       is_one
);
    logic [NDIG-1:0] dig_max, dig_zero, up_en, dn_en;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        if (g == 0) begin : g_lsd
            assign up_en[g] = up;
            assign dn_en[g] = dn;
        end else begin : g_upper
            assign up_en[g] = up & (&dig_max[g-1:0]);
            assign dn_en[g] = dn & (&dig_zero[g-1:0]);
        end

        sw_bcd_digit #(.MOD(digit_mod(g)), .W(DW)) u_digit (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .ld      (ld),
            .ld_val  (ld_val[g*DW +: DW]),
            .up      (up_en[g]),
            .dn      (dn_en[g]),
            .bump    (bump && (bump_idx == 3'(g))),
            .val     (now[g*DW +: DW]),
            .at_max  (dig_max[g]),
            .at_zero (dig_zero[g])
        );
    end

    assign is_zero = &dig_zero;
    assign is_one  = (now == time_t'(1));
endmodule

// File: rtl/sw_tick_div.sv
// One-second enable divider: pulses tick once per TICKS clock cycles while run is high.
// Held at zero while not running, so a resumed count starts a full second later.
module sw_tick_div #(
    parameter int TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int            CW   = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    // Cycle counter within the current second.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/sw_ctrl.sv
// Control state machine: mode, run, lap, digit selection, alarm and snooze.
// Assumes button inputs are synchronized one-cycle pulses; priority reset > set > mode > start/stop.
module sw_ctrl
    import sw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       b_clr,
    input  logic       b_run,
    input  logic       b_set,
    input  logic       b_mode,
    input  logic       tick,
    input  logic       t_zero,
    input  logic       t_one,
    input  time_t      t_now,
    output logic       run,
    output logic       tm,
    output logic       lap_on,
    output logic       alarm,
    output logic       snooze,
    output sel_e       sel,
    output time_t      lap_q,
    output logic       c_clr,
    output logic       c_ld,
    output logic       c_up,
    output logic       c_dn,
    output logic       c_bump,
    output logic [2:0] c_idx
);
    logic ev_snz, ev_lap, ev_sel, ev_to_tm, ev_bump, ev_ss, ev_up, ev_dn, hit_zero, locked;

    assign locked   = tm && (alarm || snooze);
    assign ev_snz   = !b_clr && tm && alarm && b_set;
    assign ev_lap   = !b_clr && !tm && b_set;
    assign ev_sel   = !b_clr && tm && !locked && b_set;
    assign ev_to_tm = !b_clr && !tm && !b_set && b_mode;
    assign ev_bump  = !b_clr && tm && !locked && !run && !b_set && b_mode;
    assign ev_ss    = !b_clr && !b_set && !b_mode && b_run && !locked;
    assign ev_up    = !b_clr && !tm && run && tick;
    assign ev_dn    = !b_clr && tm && run && tick && !t_zero;
    assign hit_zero = ev_dn && t_one;

    assign c_clr  = b_clr || ev_to_tm;
    assign c_ld   = ev_snz;
    assign c_up   = ev_up;
    assign c_dn   = ev_dn;
    assign c_bump = ev_bump;
    assign c_idx  = 3'd4 - {1'b0, sel};

    // Mode and run flags.
    always_ff @(posedge clk) begin
        if (!rst_n || b_clr) begin
            tm  <= 1'b0;
            run <= 1'b0;
        end else begin
            tm <= tm || ev_to_tm;
            if (ev_to_tm || hit_zero) run <= 1'b0;
            else if (ev_snz)          run <= 1'b1;
            else if (ev_ss)           run <= !run;
        end
    end

    // Lap view flag and snapshot register.
    always_ff @(posedge clk) begin
        if (!rst_n || b_clr) begin
            lap_on <= 1'b0;
            lap_q  <= '0;
        end else if (ev_to_tm) begin
            lap_on <= 1'b0;
        end else if (ev_lap) begin
            lap_on <= !lap_on;
            if (!lap_on) lap_q <= t_now;
        end
    end

    // Digit selection cycling H -> UM -> LM -> H.
    always_ff @(posedge clk) begin
        if (!rst_n || b_clr || ev_to_tm) sel <= SEL_HR;
        else if (ev_sel) begin
            case (sel)
                SEL_HR:  sel <= SEL_UM;
                SEL_UM:  sel <= SEL_LM;
                default: sel <= SEL_HR;
            endcase
        end
    end

    // Alarm and snooze flags.
    always_ff @(posedge clk) begin
        if (!rst_n || b_clr) begin
            alarm  <= 1'b0;
            snooze <= 1'b0;
        end else if (ev_snz) begin
            alarm  <= 1'b0;
            snooze <= 1'b1;
        end else if (hit_zero) begin
            alarm  <= 1'b1;
        end
    end
endmodule

// File: rtl/sw_timer_ctrl.sv
// Top level: stopwatch / countdown timer controller with lap display, alarm and snooze.
// Assumes a TICKS_PER_SEC Hz clock and pre-synchronized one-cycle button pulses.
module sw_timer_ctrl
    import sw_pkg::*;
#(
    parameter int TICKS_PER_SEC = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          btn_reset,
    input  logic          btn_startstop,
    input  logic          btn_set,
    input  logic          btn_modeinc,
    output logic [TW-1:0] disp_time,
    output logic          alarm_on,
    output logic          timer_mode,
    output logic          counting,
    output logic          lap_view,
    output logic          snoozing,
    output logic [1:0]    sel_digit
);
    logic       tick, run, tm, lap_on, alarm, snooze;
    logic       t_zero, t_one;
    logic       c_clr, c_ld, c_up, c_dn, c_bump;
    logic [2:0] c_idx;
    sel_e       sel;
    time_t      t_now, lap_q;

    sw_tick_div #(.TICKS(TICKS_PER_SEC)) u_div (
        .clk (clk), .rst_n (rst_n), .run (run), .tick (tick)
    );

    sw_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .b_clr  (btn_reset),
        .b_run  (btn_startstop),
        .b_set  (btn_set),
        .b_mode (btn_modeinc),
        .tick   (tick),
        .t_zero (t_zero),
        .t_one  (t_one),
        .t_now  (t_now),
        .run    (run),
        .tm     (tm),
        .lap_on (lap_on),
        .alarm  (alarm),
        .snooze (snooze),
        .sel    (sel),
        .lap_q  (lap_q),
        .c_clr  (c_clr),
        .c_ld   (c_ld),
        .c_up   (c_up),
        .c_dn   (c_dn),
        .c_bump (c_bump),
        .c_idx  (c_idx)
    );

    sw_time_cnt u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (c_clr),
        .ld       (c_ld),
        .ld_val   (SNOOZE_TIME),
        .up       (c_up),
        .dn       (c_dn),
        .bump     (c_bump),
        .bump_idx (c_idx),
        .now      (t_now),
        .is_zero  (t_zero),
        .is_one   (t_one)
    );

    assign disp_time  = lap_on ? lap_q : t_now;
    assign alarm_on   = alarm;
    assign timer_mode = tm;
    assign counting   = run;
    assign lap_view   = lap_on;
    assign snoozing   = snooze;
    assign sel_digit  = sel;
endmodule

// File: rtl/sw_timer_chk.sv
// Port-level assertion checker for sw_timer_ctrl, attached by bind.
module sw_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        btn_reset,
    input logic        btn_startstop,
    input logic        btn_set,
    input logic        btn_modeinc,
    input logic [19:0] disp_time,
    input logic        alarm_on,
    input logic        timer_mode,
    input logic        counting,
    input logic        lap_view,
    input logic        snoozing,
    input logic [1:0]  sel_digit
);
    AST_DIGITS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        disp_time[3:0] <= 4'd9 && disp_time[7:4] <= 4'd5 && disp_time[11:8] <= 4'd9
        && disp_time[15:12] <= 4'd5 && disp_time[19:16] <= 4'd9); // R2

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(btn_reset) |-> (disp_time == 20'h0 && !timer_mode && !counting && !alarm_on
                              && !snoozing && !lap_view && sel_digit == 2'd0)); // R3

    AST_SS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_mode && $past(!timer_mode) && $past(btn_startstop)
         && !$past(btn_reset || btn_set || btn_modeinc)) |-> (counting != $past(counting))); // R4

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_mode && !counting && !lap_view && $past(!timer_mode && !counting && !lap_view)
         && !$past(btn_reset)) |-> $stable(disp_time)); // R4

    AST_LAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lap_view && $past(lap_view)) |-> $stable(disp_time)); // R5

    AST_NO_LAP_IN_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        timer_mode |-> !lap_view); // R6

    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_digit != 2'd3); // R7

    AST_ALARM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_on |-> (timer_mode && !counting && disp_time == 20'h0)); // R9

    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_mode && $past(timer_mode) && $past(disp_time) == 20'h0
         && !$past(btn_set) && !$past(btn_modeinc)) |-> disp_time == 20'h0); // R10

    AST_SNOOZE_IN_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        snoozing |-> timer_mode); // R11
endmodule

bind sw_timer_ctrl sw_timer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .btn_reset     (btn_reset),
    .btn_startstop (btn_startstop),
    .btn_set       (btn_set),
    .btn_modeinc   (btn_modeinc),
    .disp_time     (disp_time),
    .alarm_on      (alarm_on),
    .timer_mode    (timer_mode),
    .counting      (counting),
    .lap_view      (lap_view),
    .snoozing      (snoozing),
    .sel_digit     (sel_digit)
);

// File: tb/sw_timer_ctrl_tb.sv
// Vector-driven bench for sw_timer_ctrl, followed by directed reset and carry tests.
module sw_timer_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        btn_reset, btn_startstop, btn_set, btn_modeinc;
    logic [19:0] disp_time;
    logic        alarm_on, timer_mode, counting, lap_view, snoozing;
    logic [1:0]  sel_digit;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sw_timer_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .btn_reset     (btn_reset),
        .btn_startstop (btn_startstop),
        .btn_set       (btn_set),
        .btn_modeinc   (btn_modeinc),
        .disp_time     (disp_time),
        .alarm_on      (alarm_on),
        .timer_mode    (timer_mode),
        .counting      (counting),
        .lap_view      (lap_view),
        .snoozing      (snoozing),
        .sel_digit     (sel_digit)
    );

    // Operations: 0 wait only, 1 reset button, 2 start/stop, 3 set, 4 mode/inc.
    // Entry: {op[2:0], wait[15:0], time[19:0], flags{alarm,timer,count,lap,snooze,sel[1:0]}, req[3:0]}
    localparam int NV = 41;
    localparam logic [49:0] VEC [NV] = '{
        {3'd2, 16'd9,    20'h00000, 7'b0010000, 4'd1 },  // R1 not yet a second
        {3'd0, 16'd1,    20'h00001, 7'b0010000, 4'd1 },  // R1 first second
        {3'd0, 16'd10,   20'h00002, 7'b0010000, 4'd1 },  // R1 second step
        {3'd3, 16'd0,    20'h00002, 7'b0011000, 4'd5 },  // R5 lap on
        {3'd0, 16'd19,   20'h00002, 7'b0011000, 4'd5 },  // R5 frozen
        {3'd3, 16'd0,    20'h00004, 7'b0010000, 4'd5 },  // R5 live again, kept counting
        {3'd2, 16'd0,    20'h00004, 7'b0000000, 4'd4 },  // R4 pause
        {3'd0, 16'd30,   20'h00004, 7'b0000000, 4'd4 },  // R4 held
        {3'd2, 16'd10,   20'h00005, 7'b0010000, 4'd1 },  // R1 restart full second
        {3'd4, 16'd20,   20'h00000, 7'b0100000, 4'd6 },  // R6 timer mode, cleared, paused
        {3'd4, 16'd0,    20'h10000, 7'b0100000, 4'd8 },  // R8 bump hour
        {3'd3, 16'd0,    20'h10000, 7'b0100001, 4'd7 },  // R7 select UM
        {3'd4, 16'd0,    20'h11000, 7'b0100001, 4'd8 },  // R8
        {3'd4, 16'd0,    20'h12000, 7'b0100001, 4'd8 },  // R8
        {3'd4, 16'd0,    20'h13000, 7'b0100001, 4'd8 },  // R8
        {3'd4, 16'd0,    20'h14000, 7'b0100001, 4'd8 },  // R8
        {3'd4, 16'd0,    20'h15000, 7'b0100001, 4'd8 },  // R8
        {3'd4, 16'd0,    20'h10000, 7'b0100001, 4'd2 },  // R2 UM wraps mod 6, no carry
        {3'd3, 16'd0,    20'h10000, 7'b0100010, 4'd7 },  // R7 select LM
        {3'd4, 16'd0,    20'h10100, 7'b0100010, 4'd8 },  // R8 bump LM
        {3'd3, 16'd0,    20'h10100, 7'b0100000, 4'd7 },  // R7 back to hour
        {3'd1, 16'd0,    20'h00000, 7'b0000000, 4'd3 },  // R3 reset button
        {3'd4, 16'd0,    20'h00000, 7'b0100000, 4'd6 },  // R6
        {3'd3, 16'd0,    20'h00000, 7'b0100001, 4'd7 },  // R7
        {3'd3, 16'd0,    20'h00000, 7'b0100010, 4'd7 },  // R7
        {3'd4, 16'd0,    20'h00100, 7'b0100010, 4'd8 },  // R8 set 0:01:00
        {3'd2, 16'd10,   20'h00059, 7'b0110010, 4'd9 },  // R9 borrow chain
        {3'd4, 16'd0,    20'h00059, 7'b0110010, 4'd8 },  // R8 ignored while counting
        {3'd0, 16'd588,  20'h00001, 7'b0110010, 4'd9 },  // R9 last second
        {3'd0, 16'd1,    20'h00000, 7'b1100010, 4'd9 },  // R9 alarm, stopped
        {3'd0, 16'd30,   20'h00000, 7'b1100010, 4'd10},  // R10 stays at zero
        {3'd2, 16'd0,    20'h00000, 7'b1100010, 4'd12},  // R12 start ignored in alarm
        {3'd4, 16'd0,    20'h00000, 7'b1100010, 4'd12},  // R12 mode ignored in alarm
        {3'd3, 16'd0,    20'h00500, 7'b0110110, 4'd11},  // R11 snooze loads 0:05:00
        {3'd0, 16'd10,   20'h00459, 7'b0110110, 4'd11},  // R11 counts down
        {3'd2, 16'd0,    20'h00459, 7'b0110110, 4'd12},  // R12 start ignored in snooze
        {3'd0, 16'd2989, 20'h00000, 7'b1100110, 4'd11},  // R11 alarm again
        {3'd1, 16'd0,    20'h00000, 7'b0000000, 4'd12},  // R12 only reset leaves
        {3'd4, 16'd0,    20'h00000, 7'b0100000, 4'd6 },  // R6
        {3'd2, 16'd30,   20'h00000, 7'b0110000, 4'd10},  // R10 start at zero: no change
        {3'd1, 16'd0,    20'h00000, 7'b0000000, 4'd3 }   // R3
    };

    task automatic check(input logic [19:0] et, input logic [6:0] ef, input int req);
        logic [6:0] af;
        af = {alarm_on, timer_mode, counting, lap_view, snoozing, sel_digit};
        n_run++;
        if (disp_time !== et || af !== ef) begin
            n_fail++;
            $display("FAIL R%0d: time %h flags %b, expected time %h flags %b",
                     req, disp_time, af, et, ef);
        end
    endtask

    // Drive one button for exactly one cycle, starting at a falling edge.
    task automatic press(input int op);
        btn_reset     = (op == 1);
        btn_startstop = (op == 2);
        btn_set       = (op == 3);
        btn_modeinc   = (op == 4);
        @(negedge clk);
        btn_reset     = 1'b0;
        btn_startstop = 1'b0;
        btn_set       = 1'b0;
        btn_modeinc   = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        btn_reset = 1'b0; btn_startstop = 1'b0; btn_set = 1'b0; btn_modeinc = 1'b0;
        repeat (3) @(negedge clk);
        check(20'h00000, 7'b0000000, 3);  // R3 state under rst_n
        rst_n = 1'b1;
        @(negedge clk);
        check(20'h00000, 7'b0000000, 3);  // R3 after release

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][49:47] != 3'd0) press(int'(VEC[i][49:47]));
            repeat (int'(VEC[i][46:31])) @(negedge clk);
            check(VEC[i][30:11], VEC[i][10:4], int'(VEC[i][3:0]));
        end

        // R2: seconds carry into minutes after sixty seconds of counting up.
        press(2);
        repeat (600) @(negedge clk);
        check(20'h00100, 7'b0010000, 2);

        // R3: rst_n in the middle of a run clears everything.
        rst_n = 1'b0;
        @(negedge clk);
        check(20'h00000, 7'b0000000, 3);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(20'h00000, 7'b0000000, 3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule